// File: doc/BRIEF.md
# Extended-Resolution Pulse-Adding PWM Generator

The generator produces a pulse-width modulated output from an 8-bit up counter that advances once per source-clock tick while running. Every counter period starts at the inactive level. The output changes to the active level when the counter reaches the duty value and returns to the inactive level when the counter wraps from its maximum to zero. A polarity input selects which level counts as active.

Sixteen consecutive periods form a frame. A 4-bit additive value picks a subset of those periods in which the active edge comes one tick late. Averaged over a frame, the inactive time then grows in steps of 1/16 tick, which gives close to 12-bit resolution from an 8-bit counter. A period is extended when the bit-reversed period index is below the additive value. This spreads the extended periods evenly across the frame, and the number of extended periods always equals the additive value.

Each counter wrap raises a one-cycle period interrupt pulse. The wrap that closes a frame also raises a frame interrupt pulse. Both pulses fall in the same system-clock cycle as the tick that causes the wrap.

Top module: `pwm_xres`

## Requirements
- R1: While the run input is 0, the counter and the period index are held at 0, and both interrupt outputs are 0. From the cycle after run is first seen low, the output is at the inactive level, which equals the polarity input (0 gives active-high, 1 gives active-low).
- R2: The counter advances only on cycles where both tick and run are 1. Cycles with tick at 0 change neither the output nor the interrupts.
- R3: Within a period, the output switches to the active level (the inverse of the polarity input) on the tick that brings the counter to the period's match value. That value is the duty value, or the duty value plus 1 in an extended period.
- R4: On a tick while the counter is 255, the counter wraps to 0 and the output returns to the inactive level. The period interrupt is 1 in that same cycle and only then.
- R5: The frame interrupt is 1 exactly on the period interrupts that close period index 15, which is every 16th wrap after run starts.
- R6: Period index k (0..15) is extended when the 4-bit bit-reverse of k is below the additive value. An additive value of 0 extends no period.
- R7: Over one complete frame with duty d in 1..254, the total number of active-level ticks equals 16·(256−d) minus the additive value.
- R8: With duty 0, the first period after run starts is wholly inactive and every unextended later period is wholly active. With duty 255 in an extended period, the match value 256 is never reached, so that period is wholly inactive.
- R9: Raising run restarts the frame at period index 0. With additive value 1, only the first period after the restart is extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Source-clock enable, one count per cycle where it is 1 |
| run_i | input | 1 | Counting enable; 0 holds the generator stopped |
| duty_i | input | 8 | Duty value compared with the counter |
| add_i | input | 4 | Additive value selecting the extended periods of a frame |
| pol_i | input | 1 | Output polarity: 0 active-high, 1 active-low |
| pwm_o | output | 1 | PWM output |
| irq_period_o | output | 1 | One-cycle pulse on each counter wrap |
| irq_frame_o | output | 1 | One-cycle pulse on each 16th wrap |

## Verification
The bench builds the block with its default widths: an 8-bit counter and a 4-bit additive value. Periods are then 256 ticks and frames 4096 ticks, so whole frames can be run with a tick every cycle. The bench can then count the active time of a full frame for several additive values and see every one of the 16 bit-reversed period positions. It can also reach the duty extremes 0 and 255, where the match value reaches 0 or 256.

// File: rtl/pwm_xres_pkg.sv
package pwm_xres_pkg;

  localparam int unsigned DEF_CNT_W = 8;
  localparam int unsigned DEF_ADD_W = 4;

  typedef enum logic {
    POL_ACT_HIGH = 1'b0,
    POL_ACT_LOW  = 1'b1
  } pwm_pol_e;

  // Period extension decision: true when the reversed index ranks below the additive value.
  function automatic logic ext_pick(input logic [7:0] rev_idx, input logic [7:0] add_val);
    return rev_idx < add_val;
  endfunction

endpackage

// File: rtl/pwm_xres_rstsync.sv
module pwm_xres_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pwm_xres_timebase.sv
module pwm_xres_timebase #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic [IDX_W-1:0] idx_nxt_o,
  output logic             step_o,
  output logic             wrap_o,
  output logic             frame_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};
  localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             step, wrap, cnt_en, idx_en;

  always_comb begin
    step   = run_i & tick_i;
    wrap   = step & (cnt_q == CNT_LAST);
    cnt_en = !run_i || step;
    idx_en = !run_i || wrap;
    if (!run_i) begin
      cnt_d = '0;
      idx_d = '0;
    end else begin
      cnt_d = step ? cnt_q + CNT_W'(1) : cnt_q;
      idx_d = wrap ? idx_q + IDX_W'(1) : idx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign cnt_nxt_o = cnt_d;
  assign idx_nxt_o = idx_d;
  assign step_o    = step;
  assign wrap_o    = wrap;
  assign frame_o   = wrap & (idx_q == IDX_LAST);

endmodule

// File: rtl/pwm_xres_dither.sv
module pwm_xres_dither
  import pwm_xres_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [IDX_W-1:0] add_i,
  output logic [CNT_W:0]   match_o
);

  logic [IDX_W-1:0] rev_idx;
  logic             ext;

  for (genvar b = 0; b < IDX_W; b++) begin : g_rev
    assign rev_idx[b] = idx_i[IDX_W-1-b];
  end

  always_comb begin
    ext     = ext_pick(8'(rev_idx), 8'(add_i));
    match_o = {1'b0, duty_i} + (CNT_W+1)'(ext);
  end

endmodule

// File: rtl/pwm_xres_outstage.sv
module pwm_xres_outstage #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             step_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W:0]   match_i,
  input  logic             pol_i,
  output logic             pwm_o
);

  logic act_q, act_d, hit;

  always_comb begin
    hit   = ({1'b0, cnt_nxt_i} == match_i);
    act_d = act_q;
    if (!run_i) begin
      act_d = 1'b0;
    end else if (step_i) begin
      if (hit) begin
        act_d = 1'b1;
      end else if (wrap_i) begin
        act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
    end
  end

  assign pwm_o = act_q ^ pol_i;

endmodule

// File: rtl/pwm_xres.sv
module pwm_xres
  import pwm_xres_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned ADD_W = DEF_ADD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [ADD_W-1:0] add_i,
  input  logic             pol_i,
  output logic             pwm_o,
  output logic             irq_period_o,
  output logic             irq_frame_o
);

  logic             rst_int_n;
  logic [CNT_W-1:0] cnt_nxt;
  logic [ADD_W-1:0] idx_nxt;
  logic [CNT_W:0]   match;
  logic             step, wrap, frame;

  pwm_xres_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pwm_xres_timebase #(.CNT_W(CNT_W), .IDX_W(ADD_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_i    (tick_i),
    .run_i     (run_i),
    .cnt_nxt_o (cnt_nxt),
    .idx_nxt_o (idx_nxt),
    .step_o    (step),
    .wrap_o    (wrap),
    .frame_o   (frame)
  );

  pwm_xres_dither #(.CNT_W(CNT_W), .IDX_W(ADD_W)) u_dith (
    .idx_i   (idx_nxt),
    .duty_i  (duty_i),
    .add_i   (add_i),
    .match_o (match)
  );

  pwm_xres_outstage #(.CNT_W(CNT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run_i     (run_i),
    .step_i    (step),
    .wrap_i    (wrap),
    .cnt_nxt_i (cnt_nxt),
    .match_i   (match),
    .pol_i     (pol_i),
    .pwm_o     (pwm_o)
  );

  assign irq_period_o = wrap;
  assign irq_frame_o  = frame;

endmodule

// File: rtl/pwm_xres_chk.sv
module pwm_xres_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned ADD_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             run_i,
  input logic [CNT_W-1:0] duty_i,
  input logic             pol_i,
  input logic             pwm_o,
  input logic             irq_period_o,
  input logic             irq_frame_o
);

  localparam logic [ADD_W-1:0] WRAP_LAST = {ADD_W{1'b1}};

  logic [ADD_W-1:0] wraps_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wraps_q <= '0;
    end else if (!run_i) begin
      wraps_q <= '0;
    end else if (irq_period_o) begin
      wraps_q <= wraps_q + ADD_W'(1);
    end
  end

  // R1
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> (!irq_period_o && !irq_frame_o));

  // R1
  stopped_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && $past(!run_i)) |-> (pwm_o == pol_i));

  // R4
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period_o |-> (tick_i && run_i));

  // R4
  wrap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_period_o && duty_i != '0) |=> (pwm_o == pol_i));

  // R5
  frame_every_sixteenth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period_o |-> (irq_frame_o == (wraps_q == WRAP_LAST)));

  // R5
  frame_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_frame_o |-> irq_period_o);

  // R2
  edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && $stable(pol_i) && !$past(tick_i)) |-> $stable(pwm_o));

endmodule

bind pwm_xres pwm_xres_chk #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .run_i        (run_i),
  .duty_i       (duty_i),
  .pol_i        (pol_i),
  .pwm_o        (pwm_o),
  .irq_period_o (irq_period_o),
  .irq_frame_o  (irq_frame_o)
);

// File: tb/test_pwm_xres.sv
module test_pwm_xres;

  localparam int CW  = 8;
  localparam int AW  = 4;
  localparam int PER = 1 << CW;
  localparam int FRM = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_i, run_i, pol_i;
  logic [CW-1:0] duty_i;
  logic [AW-1:0] add_i;
  logic          pwm_o, irq_period_o, irq_frame_o;

  always #2 clk = ~clk;

  pwm_xres #(.CNT_W(CW), .ADD_W(AW)) i_pwm_xres (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .run_i        (run_i),
    .duty_i       (duty_i),
    .add_i        (add_i),
    .pol_i        (pol_i),
    .pwm_o        (pwm_o),
    .irq_period_o (irq_period_o),
    .irq_frame_o  (irq_frame_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  // reference state
  int mp = 0;
  int mk = 0;
  bit mfirst = 1'b1;

  function automatic int rev_idx(int k);
    int r = 0;
    for (int i = 0; i < AW; i++) if (k[i]) r |= 1 << (AW - 1 - i);
    return r;
  endfunction

  function automatic int match_of(int d, int a, int k);
    return d + ((rev_idx(k) < a) ? 1 : 0);
  endfunction

  function automatic bit exp_act(int p, int k, bit first, int d, int a);
    int m = match_of(d, a, k);
    if (m == 0) return !first;
    return p >= m;
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, actual, expected, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n || !run_i) begin
      mp = 0; mk = 0; mfirst = 1'b1;
    end else if (tick_i) begin
      if (mp == PER - 1) begin
        mp = 0; mk = (mk + 1) % FRM; mfirst = 1'b0;
      end else begin
        mp++;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      bit e_pwm, e_ip, e_if;
      e_pwm = exp_act(mp, mk, mfirst, int'(duty_i), int'(add_i)) ^ pol_i;
      e_ip  = run_i && tick_i && (mp == PER - 1);
      e_if  = e_ip && (mk == FRM - 1);
      check(pwm_o === e_pwm, run_i ? "R3/R6/R8/R9 pwm level" : "R1 stopped level",
            int'(pwm_o), int'(e_pwm));
      check(irq_period_o === e_ip, "R2/R4 period irq", int'(irq_period_o), int'(e_ip));
      check(irq_frame_o === e_if, "R5 frame irq", int'(irq_frame_o), int'(e_if));
    end
  end

  task automatic drive(bit run, bit tick, int d, int a, bit pol);
    @(posedge clk);
    #1;
    run_i = run; tick_i = tick; duty_i = CW'(d); add_i = AW'(a); pol_i = pol;
  endtask

  task automatic stop_for(int n);
    drive(1'b0, 1'b0, int'(duty_i), int'(add_i), pol_i);
    repeat (n) @(posedge clk);
  endtask

  // Runs one full frame with a tick every cycle, counting at the negedges.
  task automatic run_frame(int d, int a, bit pol);
    int act_cnt = 0, ip_cnt = 0, if_cnt = 0;
    stop_for(3);
    drive(1'b1, 1'b1, d, a, pol);
    repeat (PER * FRM) begin
      @(negedge clk);
      if (pwm_o != pol) act_cnt++;
      if (irq_period_o) ip_cnt++;
      if (irq_frame_o) if_cnt++;
    end
    if (a == 0)
      check(act_cnt == FRM * (PER - d), "R6 no extension frame total", act_cnt, FRM * (PER - d));
    else
      check(act_cnt == FRM * (PER - d) - a, "R7 frame active total", act_cnt, FRM * (PER - d) - a);
    check(ip_cnt == FRM, "R4 period irq count", ip_cnt, FRM);
    check(if_cnt == 1, "R5 frame irq count", if_cnt, 1);
  endtask

  // Samples s = 0.. after run rises; returns first active sample in [lo,hi] and count there.
  task automatic probe(int lo, int hi, output int first_act, output int act_cnt);
    first_act = -1; act_cnt = 0;
    for (int s = 0; s <= hi; s++) begin
      @(negedge clk);
      if (s >= lo && pwm_o != pol_i) begin
        act_cnt++;
        if (first_act < 0) first_act = s;
      end
    end
  endtask

  initial begin
    int fa, ac;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; run_i = 1'b0; tick_i = 1'b0; duty_i = '0; add_i = '0; pol_i = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    chk_en = 1'b1;
    @(negedge clk);
    check(pwm_o == 1'b0 && !irq_period_o && !irq_frame_o, "R1 reset state",
          int'({pwm_o, irq_period_o, irq_frame_o}), 0);
    drive(1'b0, 1'b1, 10, 3, 1'b1);
    @(negedge clk);
    check(pwm_o == 1'b1, "R1 inactive level pol 1", int'(pwm_o), 1);

    // R2: running with no ticks leaves output and irqs quiet
    drive(1'b1, 1'b0, 0, 0, 1'b0);
    repeat (40) begin
      @(negedge clk);
      check(pwm_o == 1'b0 && !irq_period_o, "R2 no tick no change",
            int'({pwm_o, irq_period_o}), 0);
    end

    run_frame(128, 0, 1'b0);
    run_frame(128, 5, 1'b0);
    run_frame(100, 15, 1'b1);
    run_frame(1, 8, 1'b0);
    run_frame(254, 3, 1'b1);

    // R9: restart mid-frame, only period 0 extended with additive 1
    stop_for(2);
    drive(1'b1, 1'b1, 50, 1, 1'b0);
    repeat (1000) @(posedge clk);
    stop_for(2);
    drive(1'b1, 1'b1, 50, 1, 1'b0);
    probe(0, PER - 1, fa, ac);
    check(fa == 51, "R9 first period extended after restart", fa, 51);
    probe(0, PER - 1, fa, ac);
    check(fa == 50, "R9 second period not extended (R3 edge at duty)", fa, 50);

    // R8: duty 0 extremes
    stop_for(2);
    drive(1'b1, 1'b1, 0, 0, 1'b0);
    probe(0, PER - 1, fa, ac);
    check(ac == 0, "R8 duty 0 first period inactive", ac, 0);
    probe(0, PER - 1, fa, ac);
    check(ac == PER, "R8 duty 0 later period fully active", ac, PER);

    // R8: duty 255 extended period never reaches its match
    stop_for(2);
    drive(1'b1, 1'b1, 255, 15, 1'b1);
    probe(0, PER - 1, fa, ac);
    check(ac == 0, "R8 duty 255 extended period inactive", ac, 0);

    // constrained random segments
    for (int seg = 0; seg < 25; seg++) begin
      int d = $urandom % PER;
      int a = $urandom % FRM;
      bit pl = 1'($urandom % 2);
      int dens = 1 + ($urandom % 3);
      int len = 200 + ($urandom % 2500);
      if (seg % 5 == 0) d = (seg % 10 == 0) ? 0 : PER - 1;
      stop_for(1 + ($urandom % 4));
      for (int c = 0; c < len; c++) begin
        drive(1'b1, ($urandom % dens) == 0, d, a, pl);
      end
    end
    stop_for(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule